// File: doc/BRIEF.md
# Streaming Intel HEX Record Decoder

This block turns a stream of ASCII characters, one byte per handshake, into absolute-address data bytes for a flash writer. It finds each record by its leading colon, assembles the hex digit pairs into the count, the 16-bit address field, the type, the data and the checksum, and decides at the line terminator whether the record is good. Data bytes are held inside the block until the whole record has been checked. Only then are they released, one per cycle, each tagged with its full 32-bit address.

Two kinds of address record move a base that is added to every later data record. An extended linear record supplies the upper sixteen address bits. An extended segment record supplies a paragraph value that is shifted left by four. The block also remembers where the last accepted data record ended. Any data record that starts below that point is refused with an order error, so a programmer that can only write sequentially never receives bytes it would misplace. An end-of-file record parks the decoder until a restart pulse.

Top module: `ihex_stream_decoder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, eof_seen is 0 and all four error outputs are 0.
- R2: Hex digits are accepted in upper and lower case. A record of type 0x00 that passes every check releases its N data bytes on N consecutive cycles, beginning the cycle after its terminator is accepted. Byte i carries the address base + field + i. While bytes are being released, in_ready is 0.
- R3: When the modulo-256 sum of all byte pairs in a record, checksum included, is not zero, err_checksum pulses and no data byte of that record is released.
- R4: A type 0x04 record with count 2 and address field 0x0000 sets the base to its 16-bit value shifted left by 16. That base applies to every following data record until another address record replaces it.
- R5: A type 0x02 record with count 2 and address field 0x0000 sets the base to its 16-bit value shifted left by 4.
- R6: A data record whose absolute start address is below the end address (start + count) of the last accepted data record pulses err_order and releases nothing. A start equal to that end is accepted.
- R7: err_format pulses in any of these cases, and the decoder then waits for a new colon: a character inside a record that is not a hex digit, CR (0x0D) or LF (0x0A); an odd number of digits or fewer than five pairs at the terminator; an unknown type; or a nonzero address field on an address record.
- R8: Outside a record, CR, LF and every other character except the colon are consumed without effect.
- R9: err_length pulses when the count field differs from the number of data pairs received, when a data record's count exceeds DATA_MAX, when an address record's count is not 2, or when an end-of-file record's count is not 0.
- R10: A valid type 0x01 record sets eof_seen. After that, input is consumed and ignored, with no bytes and no errors, until a restart pulse. The restart clears eof_seen, the base and the order history.
- R11: Each rejected record produces exactly one single-cycle error pulse, on exactly one of the four error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous pulse that returns the decoder to its reset state |
| in_valid | input | 1 | An input character is offered |
| in_char | input | 8 | ASCII character |
| in_ready | output | 1 | The character is taken on this edge when in_valid is 1 |
| in_ready | output | 1 | (see above) |
| out_valid | output | 1 | A released data byte is present |
| out_addr | output | 32 | Absolute address of the released byte |
| out_data | output | 8 | Released data byte |
| eof_seen | output | 1 | An end-of-file record has been accepted |
| err_format | output | 1 | Pulse: malformed record |
| err_length | output | 1 | Pulse: count field mismatch |
| err_checksum | output | 1 | Pulse: checksum mismatch |
| err_order | output | 1 | Pulse: record address below the previous end |

## Verification
Records are built in the bench with checksums computed there, in both digit cases, so that accepted bytes can be compared address by address against base + field + index. Corrupted variants each flip one property: a wrong checksum, a count that disagrees with the data, a foreign character, a record that starts below the previous end, and one that starts exactly at it. Each variant must raise only its own error. Stray terminators and junk between records, address records of both kinds, and input after end-of-file followed by a restart show that the base, the order history and the end-of-file state are kept and cleared only when they should be.

// File: rtl/ihex_pkg.sv
package ihex_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_RECV,
        ST_DRAIN,
        ST_DONE
    } dec_state_e;

    typedef enum logic [2:0] {
        VERD_OK,
        VERD_FMT,
        VERD_LEN,
        VERD_SUM,
        VERD_ORDER
    } verdict_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_DATA,
        ACT_EOF,
        ACT_BASE
    } action_e;

    localparam logic [7:0] TYPE_DATA = 8'h00;
    localparam logic [7:0] TYPE_EOF  = 8'h01;
    localparam logic [7:0] TYPE_SEG  = 8'h02;
    localparam logic [7:0] TYPE_LIN  = 8'h04;

    localparam int unsigned HDR_PAIRS = 4;

endpackage

// File: rtl/ihex_char_class.sv
module ihex_char_class (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic       is_colon,
    output logic       is_eol,
    output logic [3:0] nib
);
    always_comb begin
        is_hex   = 1'b0;
        nib      = 4'h0;
        is_colon = (ch == 8'h3A);
        is_eol   = (ch == 8'h0D) || (ch == 8'h0A);
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            is_hex = 1'b1;
            nib    = 4'(ch - 8'h57);
        end
    end
endmodule

// File: rtl/ihex_byte_buf.sv
module ihex_byte_buf #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ihex_rec_check.sv
module ihex_rec_check
    import ihex_pkg::*;
#(
    parameter int unsigned DATA_MAX = 16
) (
    input  logic        odd_digits,
    input  logic [8:0]  npairs,
    input  logic [7:0]  cnt,
    input  logic [15:0] addr16,
    input  logic [7:0]  rtype,
    input  logic        sum_ok,
    input  logic [31:0] abs_addr,
    input  logic [31:0] last_end,
    output verdict_e    verdict,
    output action_e     action
);
    always_comb begin
        verdict = VERD_OK;
        action  = ACT_NONE;
        if (odd_digits || npairs < 9'(HDR_PAIRS + 1)) begin
            verdict = VERD_FMT;
        end else if ((npairs - 9'(HDR_PAIRS + 1)) != {1'b0, cnt}) begin
            verdict = VERD_LEN;
        end else if (!sum_ok) begin
            verdict = VERD_SUM;
        end else begin
            case (rtype)
                TYPE_DATA: begin
                    if (32'(cnt) > DATA_MAX)     verdict = VERD_LEN;
                    else if (abs_addr < last_end) verdict = VERD_ORDER;
                    else                          action  = ACT_DATA;
                end
                TYPE_EOF: begin
                    if (cnt != 8'd0) verdict = VERD_LEN;
                    else             action  = ACT_EOF;
                end
                TYPE_SEG, TYPE_LIN: begin
                    if (cnt != 8'd2)           verdict = VERD_LEN;
                    else if (addr16 != 16'h0)  verdict = VERD_FMT;
                    else                       action  = ACT_BASE;
                end
                default: verdict = VERD_FMT;
            endcase
        end
    end
endmodule

// File: rtl/ihex_stream_decoder.sv
module ihex_stream_decoder
    import ihex_pkg::*;
#(
    parameter int unsigned DATA_MAX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        in_valid,
    input  logic [7:0]  in_char,
    output logic        in_ready,
    output logic        out_valid,
    output logic [31:0] out_addr,
    output logic [7:0]  out_data,
    output logic        eof_seen,
    output logic        err_format,
    output logic        err_length,
    output logic        err_checksum,
    output logic        err_order
);
    localparam int unsigned DEPTH = (DATA_MAX > 1) ? DATA_MAX : 2;
    localparam int unsigned AW    = $clog2(DEPTH);

    typedef struct packed {
        dec_state_e  st;
        logic [3:0]  hi;
        logic        half;
        logic [8:0]  npairs;
        logic [7:0]  cnt;
        logic [15:0] addr16;
        logic [7:0]  rtype;
        logic [15:0] ext;
        logic [7:0]  sum;
        logic [31:0] base;
        logic [31:0] last_end;
        logic [31:0] start;
        logic [7:0]  rd;
        logic        e_fmt;
        logic        e_len;
        logic        e_sum;
        logic        e_ord;
    } dec_regs_t;

    localparam dec_regs_t REGS_INIT = '{
        st: ST_HUNT, hi: 4'h0, half: 1'b0, npairs: 9'd0, cnt: 8'd0,
        addr16: 16'h0, rtype: 8'h0, ext: 16'h0, sum: 8'h0, base: 32'h0,
        last_end: 32'h0, start: 32'h0, rd: 8'd0,
        e_fmt: 1'b0, e_len: 1'b0, e_sum: 1'b0, e_ord: 1'b0
    };

    dec_regs_t q, d;

    logic       c_hex, c_colon, c_eol;
    logic [3:0] c_nib;

    ihex_char_class u_class (
        .ch       (in_char),
        .is_hex   (c_hex),
        .is_colon (c_colon),
        .is_eol   (c_eol),
        .nib      (c_nib)
    );

    logic [31:0] rec_abs;
    verdict_e    verdict;
    action_e     action;

    assign rec_abs = q.base + {16'h0, q.addr16};

    ihex_rec_check #(.DATA_MAX(DATA_MAX)) u_check (
        .odd_digits (q.half),
        .npairs     (q.npairs),
        .cnt        (q.cnt),
        .addr16     (q.addr16),
        .rtype      (q.rtype),
        .sum_ok     (q.sum == 8'h00),
        .abs_addr   (rec_abs),
        .last_end   (q.last_end),
        .verdict    (verdict),
        .action     (action)
    );

    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [7:0]    buf_wdata;
    logic [7:0]    buf_rdata;
    logic [8:0]    data_idx;
    logic [7:0]    byte_v;

    ihex_byte_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (q.rd[AW-1:0]),
        .rdata (buf_rdata)
    );

    assign data_idx  = q.npairs - 9'(HDR_PAIRS);
    assign byte_v    = {q.hi, c_nib};
    assign buf_wdata = byte_v;
    assign buf_waddr = data_idx[AW-1:0];

    always_comb begin
        d       = q;
        d.e_fmt = 1'b0;
        d.e_len = 1'b0;
        d.e_sum = 1'b0;
        d.e_ord = 1'b0;
        buf_we  = 1'b0;
        if (restart) begin
            d = REGS_INIT;
        end else begin
            case (q.st)
                ST_HUNT: begin
                    if (in_valid && c_colon) begin
                        d.st     = ST_RECV;
                        d.half   = 1'b0;
                        d.npairs = 9'd0;
                        d.sum    = 8'h00;
                    end
                end
                ST_RECV: begin
                    if (in_valid) begin
                        if (c_hex) begin
                            if (!q.half) begin
                                d.hi   = c_nib;
                                d.half = 1'b1;
                            end else begin
                                d.half = 1'b0;
                                d.sum  = q.sum + byte_v;
                                if (q.npairs != 9'h1FF) d.npairs = q.npairs + 9'd1;
                                case (q.npairs)
                                    9'd0: d.cnt          = byte_v;
                                    9'd1: d.addr16[15:8] = byte_v;
                                    9'd2: d.addr16[7:0]  = byte_v;
                                    9'd3: d.rtype        = byte_v;
                                    9'd4: d.ext[15:8]    = byte_v;
                                    9'd5: d.ext[7:0]     = byte_v;
                                    default: ;
                                endcase
                                if (q.npairs >= 9'(HDR_PAIRS) && data_idx < 9'(DEPTH))
                                    buf_we = 1'b1;
                            end
                        end else if (c_eol) begin
                            d.st = ST_HUNT;
                            case (verdict)
                                VERD_FMT:   d.e_fmt = 1'b1;
                                VERD_LEN:   d.e_len = 1'b1;
                                VERD_SUM:   d.e_sum = 1'b1;
                                VERD_ORDER: d.e_ord = 1'b1;
                                default: ;
                            endcase
                            case (action)
                                ACT_DATA: begin
                                    d.start    = rec_abs;
                                    d.last_end = rec_abs + {24'h0, q.cnt};
                                    d.rd       = 8'd0;
                                    if (q.cnt != 8'd0) d.st = ST_DRAIN;
                                end
                                ACT_EOF:  d.st = ST_DONE;
                                ACT_BASE: begin
                                    if (q.rtype == TYPE_LIN) d.base = {q.ext, 16'h0};
                                    else                     d.base = {12'h0, q.ext, 4'h0};
                                end
                                default: ;
                            endcase
                        end else begin
                            d.st    = ST_HUNT;
                            d.e_fmt = 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    d.rd = q.rd + 8'd1;
                    if (q.rd == q.cnt - 8'd1) d.st = ST_HUNT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_INIT;
        else        q <= d;
    end

    assign in_ready     = (q.st != ST_DRAIN);
    assign out_valid    = (q.st == ST_DRAIN);
    assign out_addr     = q.start + {24'h0, q.rd};
    assign out_data     = buf_rdata;
    assign eof_seen     = (q.st == ST_DONE);
    assign err_format   = q.e_fmt;
    assign err_length   = q.e_len;
    assign err_checksum = q.e_sum;
    assign err_order    = q.e_ord;

    // R2: the input is stalled for as long as bytes are released
    a_r2_stall_during_release: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R2: released bytes walk up the address space one step per cycle
    a_r2_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_addr == $past(out_addr) + 32'd1);

    // R11: never two error kinds at once
    a_r11_one_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_format, err_length, err_checksum, err_order}));

    // R11: an error is a single-cycle pulse
    a_r11_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (err_format || err_length || err_checksum || err_order) |=>
        !(err_format || err_length || err_checksum || err_order));

    // R10: end-of-file state holds until restart
    a_r10_eof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_seen && !restart) |=> eof_seen);

    // R10: nothing comes out after end-of-file
    a_r10_quiet_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_seen && $past(eof_seen)) |->
        !(out_valid || err_format || err_length || err_checksum || err_order));

    // R3: a checksum error is never followed by a release
    a_r3_no_release_on_bad_sum: assert property (@(posedge clk) disable iff (!rst_n)
        err_checksum |-> !out_valid);
endmodule

// File: tb/sim_ihex_stream_decoder.sv
`timescale 1ns/1ps
module sim_ihex_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_ready, out_valid, eof_seen;
    logic [31:0] out_addr;
    logic [7:0]  out_data;
    logic        err_format, err_length, err_checksum, err_order;

    always #2.5 clk = ~clk;

    ihex_stream_decoder u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .eof_seen(eof_seen), .err_format(err_format), .err_length(err_length),
        .err_checksum(err_checksum), .err_order(err_order)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] cap_addr [64];
    logic [7:0]  cap_data [64];
    int ncap = 0;
    int n_fmt = 0, n_len = 0, n_sum = 0, n_ord = 0, rdy_viol = 0;
    logic [7:0] tx [32];

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                cap_addr[ncap] = out_addr;
                cap_data[ncap] = out_data;
                if (ncap < 63) ncap++;
                if (in_ready) rdy_viol++;
            end
            if (err_format)   n_fmt++;
            if (err_length)   n_len++;
            if (err_checksum) n_sum++;
            if (err_order)    n_ord++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        #1;
        ncap = 0; n_fmt = 0; n_len = 0; n_sum = 0; n_ord = 0; rdy_viol = 0;
    endtask

    task automatic send_char(input logic [7:0] c);
        forever begin
            @(negedge clk);
            in_valid = 1'b1;
            in_char  = c;
            if (in_ready) begin
                @(posedge clk);
                break;
            end
        end
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] v, input bit lower);
        if (v < 4'd10) return 8'h30 + 8'(v);
        return (lower ? 8'h57 : 8'h37) + 8'(v);
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit lower);
        send_char(hexch(b[7:4], lower));
        send_char(hexch(b[3:0], lower));
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic send_rec(input logic [7:0] cnt, input logic [15:0] addr,
                            input logic [7:0] typ, input int ndata,
                            input bit bad_sum, input bit lower);
        logic [7:0] s;
        s = cnt + addr[15:8] + addr[7:0] + typ;
        for (int i = 0; i < ndata; i++) s = s + tx[i];
        send_char(8'h3A);
        send_byte(cnt, lower);
        send_byte(addr[15:8], lower);
        send_byte(addr[7:0], lower);
        send_byte(typ, lower);
        for (int i = 0; i < ndata; i++) send_byte(tx[i], lower);
        send_byte(bad_sum ? ((~s + 8'd1) ^ 8'h5A) : (~s + 8'd1), lower);
        send_char(8'h0D);
        send_char(8'h0A);
        repeat (24) @(posedge clk);
    endtask

    task automatic expect_bytes(input string req, input int n, input logic [31:0] a0);
        chk(ncap == n, req, "byte count", 32'(ncap), 32'(n));
        for (int i = 0; i < n && i < ncap; i++) begin
            chk(cap_addr[i] == a0 + 32'(i), req, "byte address", cap_addr[i], a0 + 32'(i));
            chk(cap_data[i] == tx[i], req, "byte value", 32'(cap_data[i]), 32'(tx[i]));
        end
        chk(rdy_viol == 0, req, "in_ready during release", 32'(rdy_viol), 0);
    endtask

    task automatic expect_errs(input string req, input int f, input int l,
                               input int s, input int o);
        chk(n_fmt == f, req, "format pulses", 32'(n_fmt), 32'(f));
        chk(n_len == l, req, "length pulses", 32'(n_len), 32'(l));
        chk(n_sum == s, req, "checksum pulses", 32'(n_sum), 32'(s));
        chk(n_ord == o, req, "order pulses", 32'(n_ord), 32'(o));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 0);
        chk(eof_seen == 1'b0, "R1", "eof_seen", 32'(eof_seen), 0);
        chk({err_format, err_length, err_checksum, err_order} == 4'b0, "R1", "errors",
            32'({err_format, err_length, err_checksum, err_order}), 0);
    endtask

    task automatic t_basic_lower();   // R2
        clear_mon();
        tx[0] = 8'hab; tx[1] = 8'hcd; tx[2] = 8'hef;
        send_rec(8'd3, 16'h0010, 8'h00, 3, 1'b0, 1'b1);
        expect_bytes("R2", 3, 32'h0000_0010);
        expect_errs("R2", 0, 0, 0, 0);
    endtask

    task automatic t_linear();        // R4
        clear_mon();
        tx[0] = 8'h00; tx[1] = 8'h01;
        send_rec(8'd2, 16'h0000, 8'h04, 2, 1'b0, 1'b0);
        tx[0] = 8'h46; tx[1] = 8'h4C;
        send_rec(8'd2, 16'h2462, 8'h00, 2, 1'b0, 1'b0);
        expect_bytes("R4", 2, 32'h0001_2462);
        expect_errs("R4", 0, 0, 0, 0);
    endtask

    task automatic t_bad_sum();       // R3, R11
        clear_mon();
        tx[0] = 8'h11;
        send_rec(8'd1, 16'h2464, 8'h00, 1, 1'b1, 1'b0);
        chk(ncap == 0, "R3", "bytes after bad checksum", 32'(ncap), 0);
        expect_errs("R11", 0, 0, 1, 0);
    endtask

    task automatic t_order();         // R6
        clear_mon();
        tx[0] = 8'h22;
        send_rec(8'd1, 16'h2000, 8'h00, 1, 1'b0, 1'b0);
        chk(ncap == 0, "R6", "bytes of out-of-order record", 32'(ncap), 0);
        expect_errs("R6", 0, 0, 0, 1);
        clear_mon();
        tx[0] = 8'h33;
        send_rec(8'd1, 16'h2464, 8'h00, 1, 1'b0, 1'b0);
        expect_bytes("R6", 1, 32'h0001_2464);
        expect_errs("R6", 0, 0, 0, 0);
    endtask

    task automatic t_format();        // R7
        clear_mon();
        send_str(":10G0\r\n");
        repeat (8) @(posedge clk);
        chk(ncap == 0, "R7", "bytes after bad char", 32'(ncap), 0);
        expect_errs("R7", 1, 0, 0, 0);
        clear_mon();
        tx[0] = 8'h00; tx[1] = 8'h05;
        send_rec(8'd2, 16'h0010, 8'h04, 2, 1'b0, 1'b0);
        expect_errs("R7", 1, 0, 0, 0);
        clear_mon();
        tx[0] = 8'h44;
        send_rec(8'd1, 16'h2500, 8'h00, 1, 1'b0, 1'b0);
        expect_bytes("R7", 1, 32'h0001_2500);
    endtask

    task automatic t_length();        // R9
        clear_mon();
        tx[0] = 8'h55; tx[1] = 8'h66;
        send_rec(8'd3, 16'h2600, 8'h00, 2, 1'b0, 1'b0);
        chk(ncap == 0, "R9", "bytes of short record", 32'(ncap), 0);
        expect_errs("R9", 0, 1, 0, 0);
    endtask

    task automatic t_segment();       // R5
        clear_mon();
        tx[0] = 8'h20; tx[1] = 8'h00;
        send_rec(8'd2, 16'h0000, 8'h02, 2, 1'b0, 1'b0);
        tx[0] = 8'h77; tx[1] = 8'h88;
        send_rec(8'd2, 16'h0100, 8'h00, 2, 1'b0, 1'b0);
        expect_bytes("R5", 2, 32'h0002_0100);
        expect_errs("R5", 0, 0, 0, 0);
    endtask

    task automatic t_junk();          // R8
        clear_mon();
        send_str("\r\n\r\n xyz#\n");
        tx[0] = 8'h99;
        send_rec(8'd1, 16'h0200, 8'h00, 1, 1'b0, 1'b0);
        expect_bytes("R8", 1, 32'h0002_0200);
        expect_errs("R8", 0, 0, 0, 0);
    endtask

    task automatic t_eof();           // R10
        clear_mon();
        send_rec(8'd0, 16'h0000, 8'h01, 0, 1'b0, 1'b0);
        @(negedge clk);
        chk(eof_seen == 1'b1, "R10", "eof_seen set", 32'(eof_seen), 1);
        tx[0] = 8'hAA;
        send_rec(8'd1, 16'h0300, 8'h00, 1, 1'b0, 1'b0);
        send_str(":zz\n");
        repeat (4) @(posedge clk);
        chk(ncap == 0, "R10", "bytes after end-of-file", 32'(ncap), 0);
        expect_errs("R10", 0, 0, 0, 0);
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(eof_seen == 1'b0, "R10", "eof_seen after restart", 32'(eof_seen), 0);
        clear_mon();
        tx[0] = 8'h12; tx[1] = 8'h34;
        send_rec(8'd2, 16'h0000, 8'h00, 2, 1'b0, 1'b0);
        expect_bytes("R10", 2, 32'h0000_0000);
        expect_errs("R10", 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic_lower();
        t_linear();
        t_bad_sum();
        t_order();
        t_format();
        t_length();
        t_segment();
        t_junk();
        t_eof();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule